// File: doc/BRIEF.md
# VGA Plane Memory Address Mapper

The block converts a byte address issued by the host into an access on a four-plane, byte-wide video memory. It recognises three memory organisations. In 16-colour planar mode the host address becomes the RAM word address unchanged: a write can reach any set of planes, and a read takes one chosen plane. In text odd/even mode the lowest host address bit chooses between the character plane and the attribute plane. Doubleword mode does the same, but spreads consecutive characters four RAM words apart. Font bytes are reached through planar mode on plane 2.

Every access also produces the byte offset the same cell would have in a linear aperture. In that aperture the planes are interleaved at a stride of 4 or 8 bytes, chosen by a parameter. All outputs leave one register stage, so each result appears one clock after its request.

Top module: `vga_plane_mapper`

## Requirements
- R1: While reset is held, and on the first clock edge after it is applied, every output reads zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge. A changed input does not alter any output before the next edge.
- R3: In planar mode (modeSel 2'b00), the RAM word address equals the host address, zero-extended to 17 bits. The linear offset equals word × stride + readPlaneSel.
- R4: In planar mode, a write asserts ramWrStb equal to planeWrEn (bit p drives plane p). A read asserts ramRdEn, and rdLaneSel equals readPlaneSel.
- R5: modeSel 2'b11 gives exactly the results of planar mode.
- R6: In odd/even mode (modeSel 2'b01), host address 2n+b (b = 0 or 1) selects plane b at RAM word 2n. With a stride of 4, character n therefore lies at linear offset 8n and its attribute at 8n+1.
- R7: In odd/even mode, a write asserts at most ramWrStb bit b, and only if planeWrEn bit b is set. A read ignores readPlaneSel and returns rdLaneSel = b.
- R8: In doubleword mode (modeSel 2'b10), host address 2n+b selects plane b at RAM word 4n. With a stride of 4, this gives linear offsets 16n and 16n+1. The plane and strobe rules of R7 apply.
- R9: When accValid is low, ramWrStb is 4'b0000 and ramRdEn is 0 on the following cycle.
- R10: With PLANES = 8, the linear offset is word × 8 + plane. With PLANES = 4, it is word × 4 + plane.
- R11: ramWrData equals the wrData sampled one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostAddr | input | 16 | Host byte address |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| wrData | input | 8 | Host write byte |
| modeSel | input | 2 | 00 planar, 01 odd/even, 10 doubleword, 11 treated as planar |
| planeWrEn | input | 4 | Write plane enable bitmap |
| readPlaneSel | input | 2 | Plane read in planar mode |
| ramWordAddr | output | 17 | Word address presented to all planes |
| ramWrStb | output | 4 | Per-plane write strobes |
| ramWrData | output | 8 | Byte written to the strobed planes |
| ramRdEn | output | 1 | Read request |
| rdLaneSel | output | 2 | Plane whose byte returns to the host |
| linOffset | output | 19 | Equivalent linear-aperture byte offset |

## Verification
The assertions assume that modeSel, planeWrEn and readPlaneSel hold a known value on every clock edge outside reset. They also assume that one request per cycle is a complete transaction, with no hold-over from an earlier cycle. The stimulus changes all inputs only on falling edges. It draws modes from all four encodings, including the reserved one, and draws addresses across the full 16-bit range. Its directed cases cover the top address, disabled-plane writes, and reads with an ignored plane select.

// File: rtl/vga_map_pkg.sv
package vga_map_pkg;

  typedef enum logic [1:0] {
    MODE_PLANAR  = 2'b00,
    MODE_ODDEVEN = 2'b01,
    MODE_DWORD   = 2'b10,
    MODE_RSVD    = 2'b11
  } map_mode_e;

  // How the host address is folded into a RAM word address
  typedef enum logic [1:0] {
    FORM_DIRECT = 2'b00,
    FORM_EVEN   = 2'b01,
    FORM_QUAD   = 2'b10
  } word_form_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    word_form_e  form;
    logic [1:0]  planeIdx;
    logic [3:0]  wrMask;
    logic        doRead;
    logic        doWrite;
  } map_ctl_t;

endpackage

// File: rtl/vga_map_ctrl.sv
module vga_map_ctrl
  import vga_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] modeSel,
  input  logic       addrLsb,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic [3:0] planeWrEn,
  input  logic [1:0] readPlaneSel,
  output map_ctl_t   ctl
);

  map_mode_e mode;
  logic      pairMode;
  logic [3:0] lsbPlaneBit;

  assign mode        = map_mode_e'(modeSel);
  assign pairMode    = (mode == MODE_ODDEVEN) || (mode == MODE_DWORD);
  assign lsbPlaneBit = addrLsb ? 4'b0010 : 4'b0001;

  always_comb begin
    ctl.doRead  = accValid && !accWrite;
    ctl.doWrite = accValid && accWrite;
    unique case (mode)
      MODE_ODDEVEN: begin
        ctl.form     = FORM_EVEN;
        ctl.planeIdx = {1'b0, addrLsb};
        ctl.wrMask   = planeWrEn & lsbPlaneBit;
      end
      MODE_DWORD: begin
        ctl.form     = FORM_QUAD;
        ctl.planeIdx = {1'b0, addrLsb};
        ctl.wrMask   = planeWrEn & lsbPlaneBit;
      end
      default: begin
        ctl.form     = FORM_DIRECT;
        ctl.planeIdx = readPlaneSel;
        ctl.wrMask   = planeWrEn;
      end
    endcase
  end

  // R7: in paired modes a write touches at most one plane
  assert_pair_single_plane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pairMode |-> ($countones(ctl.wrMask) <= 1));

  // R7: the paired-mode plane never comes from the read select
  assert_pair_plane_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pairMode |-> (ctl.planeIdx[1] == 1'b0));

  // R5: the reserved encoding behaves as planar
  assert_rsvd_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSVD) |-> (ctl.form == FORM_DIRECT && ctl.planeIdx == readPlaneSel));

endmodule

// File: rtl/vga_map_dp.sv
module vga_map_dp
  import vga_map_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int PLANES  = 4,
  parameter int DATA_W  = 8,
  localparam int WORD_W = HOST_AW + 1,
  localparam int SHIFT  = (PLANES == 8) ? 3 : 2,
  localparam int OFF_W  = WORD_W + SHIFT
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  map_ctl_t           ctl,
  output logic [WORD_W-1:0]  ramWordAddr,
  output logic [3:0]         ramWrStb,
  output logic [DATA_W-1:0]  ramWrData,
  output logic               ramRdEn,
  output logic [1:0]         rdLaneSel,
  output logic [OFF_W-1:0]   linOffset
);

  logic [WORD_W-1:0] wordNext;
  logic [OFF_W-1:0]  offNext;
  logic              pastOk;

  always_comb begin
    unique case (ctl.form)
      FORM_EVEN: wordNext = {1'b0, hostAddr[HOST_AW-1:1], 1'b0};
      FORM_QUAD: wordNext = {hostAddr[HOST_AW-1:1], 2'b00};
      default:   wordNext = {1'b0, hostAddr};
    endcase
  end

  // Interleave stride chosen by plane count
  generate
    if (PLANES == 8) begin : g_stride8
      assign offNext = {wordNext, 1'b0, ctl.planeIdx};
    end else begin : g_stride4
      assign offNext = {wordNext, ctl.planeIdx};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramWordAddr <= '0;
      ramWrStb    <= '0;
      ramWrData   <= '0;
      ramRdEn     <= 1'b0;
      rdLaneSel   <= '0;
      linOffset   <= '0;
      pastOk      <= 1'b0;
    end else begin
      ramWordAddr <= wordNext;
      ramWrStb    <= ctl.doWrite ? ctl.wrMask : 4'b0000;
      ramWrData   <= wrData;
      ramRdEn     <= ctl.doRead;
      rdLaneSel   <= ctl.planeIdx;
      linOffset   <= offNext;
      pastOk      <= 1'b1;
    end
  end

  // R9: an idle cycle produces no memory activity next cycle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && !$past(ctl.doRead) && !$past(ctl.doWrite)) |-> (ramWrStb == 4'b0000 && !ramRdEn));

  // R4: read and write never issue together
  assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramRdEn && (ramWrStb != 4'b0000)));

  // R3: planar word address follows the host address one cycle later
  assert_direct_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && $past(ctl.form) == FORM_DIRECT) |-> (ramWordAddr == WORD_W'($past(hostAddr))));

  // R6: odd/even words are always even
  assert_even_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && $past(ctl.form) == FORM_EVEN) |-> (ramWordAddr[0] == 1'b0));

  // R8: doubleword words are multiples of four
  assert_quad_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && $past(ctl.form) == FORM_QUAD) |-> (ramWordAddr[1:0] == 2'b00));

  // R10: the offset's upper bits carry the word address
  assert_offset_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    linOffset[OFF_W-1:SHIFT] == ramWordAddr);

endmodule

// File: rtl/vga_plane_mapper.sv
module vga_plane_mapper
  import vga_map_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int PLANES  = 4,
  parameter int DATA_W  = 8,
  localparam int WORD_W = HOST_AW + 1,
  localparam int SHIFT  = (PLANES == 8) ? 3 : 2,
  localparam int OFF_W  = WORD_W + SHIFT
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [1:0]         modeSel,
  input  logic [3:0]         planeWrEn,
  input  logic [1:0]         readPlaneSel,
  output logic [WORD_W-1:0]  ramWordAddr,
  output logic [3:0]         ramWrStb,
  output logic [DATA_W-1:0]  ramWrData,
  output logic               ramRdEn,
  output logic [1:0]         rdLaneSel,
  output logic [OFF_W-1:0]   linOffset
);

  map_ctl_t ctl;

  vga_map_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .modeSel      (modeSel),
    .addrLsb      (hostAddr[0]),
    .accValid     (accValid),
    .accWrite     (accWrite),
    .planeWrEn    (planeWrEn),
    .readPlaneSel (readPlaneSel),
    .ctl          (ctl)
  );

  vga_map_dp #(
    .HOST_AW (HOST_AW),
    .PLANES  (PLANES),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .hostAddr    (hostAddr),
    .wrData      (wrData),
    .ctl         (ctl),
    .ramWordAddr (ramWordAddr),
    .ramWrStb    (ramWrStb),
    .ramWrData   (ramWrData),
    .ramRdEn     (ramRdEn),
    .rdLaneSel   (rdLaneSel),
    .linOffset   (linOffset)
  );

endmodule

// File: tb/test_vga_plane_mapper.sv
module test_vga_plane_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hostAddr = '0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [7:0]  wrData = '0;
  logic [1:0]  modeSel = '0;
  logic [3:0]  planeWrEn = '0;
  logic [1:0]  readPlaneSel = '0;

  logic [16:0] ramWordAddr, wordW8;
  logic [3:0]  ramWrStb, stbW8;
  logic [7:0]  ramWrData, dataW8;
  logic        ramRdEn, rdW8;
  logic [1:0]  rdLaneSel, laneW8;
  logic [18:0] linOffset;
  logic [19:0] offW8;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vga_plane_mapper i_vga_plane_mapper (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .accValid(accValid),
    .accWrite(accWrite), .wrData(wrData), .modeSel(modeSel),
    .planeWrEn(planeWrEn), .readPlaneSel(readPlaneSel),
    .ramWordAddr(ramWordAddr), .ramWrStb(ramWrStb), .ramWrData(ramWrData),
    .ramRdEn(ramRdEn), .rdLaneSel(rdLaneSel), .linOffset(linOffset)
  );

  vga_plane_mapper #(.PLANES(8)) i_vga_plane_mapper_w8 (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .accValid(accValid),
    .accWrite(accWrite), .wrData(wrData), .modeSel(modeSel),
    .planeWrEn(planeWrEn), .readPlaneSel(readPlaneSel),
    .ramWordAddr(wordW8), .ramWrStb(stbW8), .ramWrData(dataW8),
    .ramRdEn(rdW8), .rdLaneSel(laneW8), .linOffset(offW8)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eWord(input logic [1:0] m, input int a);
    if (m == 2'b01) return (a / 2) * 2;
    if (m == 2'b10) return (a / 2) * 4;
    return a;
  endfunction

  function automatic int ePlane(input logic [1:0] m, input int a, input int rs);
    if (m == 2'b01 || m == 2'b10) return a % 2;
    return rs;
  endfunction

  function automatic logic [3:0] eMask(input logic [1:0] m, input int a, input logic [3:0] en);
    if (m == 2'b01 || m == 2'b10) return en & (4'b0001 << (a % 2));
    return en;
  endfunction

  task automatic doOp(input logic [15:0] a, input logic v, input logic w, input logic [7:0] d,
                      input logic [1:0] m, input logic [3:0] en, input logic [1:0] rs);
    int wd, pl;
    @(negedge clk);
    hostAddr = a; accValid = v; accWrite = w; wrData = d;
    modeSel = m; planeWrEn = en; readPlaneSel = rs;
    @(posedge clk); #1;
    wd = eWord(m, int'(a));
    pl = ePlane(m, int'(a), int'(rs));
    chk("R3/R6/R8 word", 32'(ramWordAddr), 32'(wd));
    chk("R10 offset stride4", 32'(linOffset), 32'(wd * 4 + pl));
    chk("R10 offset stride8", 32'(offW8), 32'(wd * 8 + pl));
    chk("R4/R7 lane", 32'(rdLaneSel), 32'(pl));
    chk("R4/R7/R9 write strobes", 32'(ramWrStb), (v && w) ? 32'(eMask(m, int'(a), en)) : 32'd0);
    chk("R4/R9 read enable", 32'(ramRdEn), 32'(v && !w));
    chk("R11 write data", 32'(ramWrData), 32'(d));
  endtask

  task automatic chkZero(input string tag);
    chk(tag, 32'(ramWordAddr) | 32'(ramWrStb) | 32'(ramWrData) | 32'(ramRdEn)
             | 32'(rdLaneSel) | 32'(linOffset) | 32'(offW8), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd7717);
    hostAddr = 16'hBEEF; wrData = 8'h5A; accValid = 1'b1; accWrite = 1'b1; planeWrEn = 4'hF;
    repeat (3) @(posedge clk);
    #1 chkZero("R1 reset state");
    @(negedge clk); rst_n = 1'b1;

    // R3/R4 planar write and read
    doOp(16'h1234, 1, 1, 8'hA5, 2'b00, 4'b1011, 2'd2);
    doOp(16'h1234, 1, 0, 8'h00, 2'b00, 4'b1011, 2'd3);
    // R5 reserved mode equals planar
    doOp(16'h4321, 1, 1, 8'h3C, 2'b11, 4'b0110, 2'd1);
    doOp(16'h0007, 1, 0, 8'h11, 2'b11, 4'b0000, 2'd2);
    // R6 odd/even: character 5 at offset 40, attribute at 41
    doOp(16'd10, 1, 0, 8'h00, 2'b01, 4'hF, 2'd3);
    chk("R6 char offset 8n", 32'(linOffset), 32'd40);
    doOp(16'd11, 1, 0, 8'h00, 2'b01, 4'hF, 2'd3);
    chk("R6 attr offset 8n+1", 32'(linOffset), 32'd41);
    chk("R7 read select ignored", 32'(rdLaneSel), 32'd1);
    // R7 write to odd address with plane 1 disabled strobes nothing
    doOp(16'd11, 1, 1, 8'h77, 2'b01, 4'b1101, 2'd0);
    chk("R7 disabled plane no strobe", 32'(ramWrStb), 32'd0);
    doOp(16'd10, 1, 1, 8'h78, 2'b01, 4'b1111, 2'd0);
    chk("R7 single plane 0", 32'(ramWrStb), 32'd1);
    // R8 doubleword: host 5 -> word 8 plane 1, offset 33
    doOp(16'd5, 1, 1, 8'h99, 2'b10, 4'hF, 2'd2);
    chk("R8 dword attr offset", 32'(linOffset), 32'd33);
    doOp(16'hFFFF, 1, 0, 8'h00, 2'b10, 4'hF, 2'd0);
    chk("R8 top address word", 32'(ramWordAddr), 32'h1FFFC);
    // R9 idle
    doOp(16'h0F0F, 0, 1, 8'h12, 2'b00, 4'hF, 2'd1);

    // R2 latency: inputs change but outputs wait for the edge
    @(negedge clk);
    hostAddr = 16'h2222; modeSel = 2'b00; accValid = 1'b1; accWrite = 1'b0;
    #1 chk("R2 no change before edge", 32'(ramWordAddr), 32'h0F0F);
    @(posedge clk); #1 chk("R2 change after edge", 32'(ramWordAddr), 32'h2222);

    for (int i = 0; i < 400; i++) begin
      doOp(16'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
           2'($urandom), 4'($urandom), 2'($urandom));
    end

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 chkZero("R1 reset after activity");
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule